// File: doc/BRIEF.md
# Static Dataflow Instruction Cell Array

This block holds a small set of instruction cells for a static dataflow processor. Each cell has a fixed operation code, one destination (a target cell index and a left/right operand selector) and two operand slots. Result tokens arrive through a single distribution port and fill the slot they address. A cell becomes enabled once both slots hold a value and its output arc has no unacknowledged token. A round-robin arbiter takes one enabled cell per clock and sends its operation packet to an execute port, where an external arithmetic unit computes the result and later returns it as a token for the destination cell.

Each arc carries at most one token at a time. Firing a cell empties its slots and marks its output arc as busy. The arc is released when the consuming cell fires, because consuming an operand acknowledges the cell that produced it. An arc that leaves the array can instead be released by an external acknowledge line. A token aimed at a slot that is already occupied breaks the one-token rule. The block drops such a token and pulses an error output.

The cell programme (operations and destinations) arrives on static configuration inputs, which an outer loader drives.

Top module: `dflow_cell_array`

## Requirements
- R1: After synchronous reset, `exe_valid_o` and `err_o` are 0, every operand slot is empty, no arc is busy, and the arbiter's search starts at cell 0.
- R2: A token with `tok_side_i` = 0 fills the left slot, and one with `tok_side_i` = 1 fills the right slot, of cell `tok_dst_i`. The slot keeps the value, the source index and the source-is-cell flag.
- R3: A cell fires only when both of its slots are full and its output arc is not busy. A cell holding a single operand never fires.
- R4: A cell chosen at clock edge k drives `exe_valid_o` high for exactly one cycle after edge k. During that cycle the packet shows its operation, destination index, destination side, left value, right value and own index on `exe_src_o`.
- R5: Firing empties both slots of the cell and marks its arc busy. The cell then does not fire again, even with both slots refilled, until that arc is released.
- R6: When a cell fires, each consumed operand whose token came from a cell (`tok_from_cell_i` = 1 at arrival) releases the busy arc of that source cell. The source cell may fire on the next edge.
- R7: `ext_ack_i[i]` = 1 at an edge releases the busy arc of cell i.
- R8: At most one cell fires per edge. The search for an enabled cell starts one index past the last cell that fired and wraps from cell 7 to cell 0.
- R9: A token addressed to a full slot is discarded, and the slot keeps its earlier contents. `err_o` is 1 for the cycle that follows that edge.
- R10: Slot occupancy is judged before the firing at the same edge. A token for a slot of the cell that fires at that edge is therefore discarded with an error and is not kept.
- R11: If a cell fires at the same edge as its own external acknowledge, the arc ends up busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_op_i | input | 32 | Operation code of each cell, 4 bits per cell, cell 0 in the low bits |
| cfg_dst_i | input | 24 | Destination cell index of each cell, 3 bits per cell |
| cfg_side_i | input | 8 | Destination slot of each cell, 0 left, 1 right |
| tok_valid_i | input | 1 | A token is presented on the distribution port |
| tok_dst_i | input | 3 | Target cell of the token |
| tok_side_i | input | 1 | Target slot, 0 left, 1 right |
| tok_data_i | input | 16 | Token value |
| tok_src_i | input | 3 | Index of the cell that produced the token |
| tok_from_cell_i | input | 1 | 1 if the token came from a cell of this array and must be acknowledged |
| ext_ack_i | input | 8 | Per-cell release of the output arc by a consumer outside the array |
| exe_valid_o | output | 1 | An operation packet is issued |
| exe_op_o | output | 4 | Operation code of the issued cell |
| exe_dst_o | output | 3 | Destination cell of the result |
| exe_side_o | output | 1 | Destination slot of the result |
| exe_lhs_o | output | 16 | Left operand |
| exe_rhs_o | output | 16 | Right operand |
| exe_src_o | output | 3 | Index of the issued cell |
| err_o | output | 1 | A token addressed to a full slot was discarded |

## Verification
The bench targets the cases where the one-token rule could break. It sends a second token into an occupied slot. A design that overwrote the slot would issue the newer value. It refills a cell that has fired but has not been released. A design that ignored the busy arc would issue twice. It sends a token to a cell in the same cycle that cell fires. A design that cleared the slot first would keep the token and later fire on a half-stale pair. It also releases several waiting cells at once and checks the issue order against the rotating priority, and it fires a cell in the same cycle as its own external release.

// File: rtl/dflow_pkg.sv
package dflow_pkg;

    localparam int CELLS  = 8;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int IDX_W  = (CELLS > 1) ? $clog2(CELLS) : 1;

    typedef logic [IDX_W-1:0]  cell_idx_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [OP_W-1:0]   op_t;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // One operand slot of a cell
    typedef struct packed {
        logic      full;
        logic      from_cell;
        cell_idx_t src;
        word_t     data;
    } slot_t;

    // Packet handed to the execute port
    typedef struct packed {
        op_t       op;
        cell_idx_t dst;
        side_e     side;
        word_t     lhs;
        word_t     rhs;
        cell_idx_t src;
    } packet_t;

    function automatic cell_idx_t next_idx(input cell_idx_t i);
        return (int'(i) == CELLS - 1) ? '0 : cell_idx_t'(int'(i) + 1);
    endfunction

    // One-hot grant of the first requester at or after 'start', wrapping
    function automatic logic [CELLS-1:0] rr_grant(input logic [CELLS-1:0] req,
                                                  input cell_idx_t        start);
        logic [CELLS-1:0] g;
        logic             found;
        g     = '0;
        found = 1'b0;
        for (int k = 0; k < CELLS; k++) begin
            int idx;
            idx = (int'(start) + k) % CELLS;
            if (!found && req[idx]) begin
                g[idx] = 1'b1;
                found  = 1'b1;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/dflow_cell.sv
module dflow_cell
    import dflow_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  side_e     wr_side,
    input  word_t     wr_data,
    input  cell_idx_t wr_src,
    input  logic      wr_from_cell,
    input  logic      fire,
    input  logic      ack_clr,
    output slot_t     lhs_q,
    output slot_t     rhs_q,
    output logic      pend_q,
    output logic      ready,
    output logic      drop
);

    slot_t incoming;
    logic  hit_l;
    logic  hit_r;

    assign incoming = '{full: 1'b1, from_cell: wr_from_cell, src: wr_src, data: wr_data};
    assign hit_l    = wr_en && (wr_side == SIDE_LEFT);
    assign hit_r    = wr_en && (wr_side == SIDE_RIGHT);

    // R9/R10: occupancy judged on the state before this edge's firing
    assign drop  = (hit_l && lhs_q.full) || (hit_r && rhs_q.full);
    // R3: both operands present and output arc free
    assign ready = lhs_q.full && rhs_q.full && !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lhs_q  <= '0;
            rhs_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (fire) begin
                lhs_q.full <= 1'b0;
                rhs_q.full <= 1'b0;
            end
            if (hit_l && !lhs_q.full) lhs_q <= incoming;
            if (hit_r && !rhs_q.full) rhs_q <= incoming;
            // R5/R11: setting the busy arc wins over a release
            if (fire)         pend_q <= 1'b1;
            else if (ack_clr) pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dflow_rr_arb.sv
module dflow_rr_arb
    import dflow_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CELLS-1:0] req,
    output logic [CELLS-1:0] gnt,
    output cell_idx_t        gnt_idx,
    output logic             gnt_any
);

    cell_idx_t ptr_q;

    assign gnt     = rr_grant(req, ptr_q);
    assign gnt_any = |req;

    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < CELLS; i++) begin
            if (gnt[i]) gnt_idx = cell_idx_t'(i);
        end
    end

    // R8: next search begins one past the last granted cell
    always_ff @(posedge clk) begin
        if (rst)          ptr_q <= '0;
        else if (gnt_any) ptr_q <= next_idx(gnt_idx);
    end

endmodule

// File: rtl/dflow_cell_array.sv
module dflow_cell_array
    import dflow_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CELLS*OP_W-1:0] cfg_op_i,
    input  logic [CELLS*IDX_W-1:0] cfg_dst_i,
    input  logic [CELLS-1:0]      cfg_side_i,
    input  logic                  tok_valid_i,
    input  logic [IDX_W-1:0]      tok_dst_i,
    input  logic                  tok_side_i,
    input  logic [DATA_W-1:0]     tok_data_i,
    input  logic [IDX_W-1:0]      tok_src_i,
    input  logic                  tok_from_cell_i,
    input  logic [CELLS-1:0]      ext_ack_i,
    output logic                  exe_valid_o,
    output logic [OP_W-1:0]       exe_op_o,
    output logic [IDX_W-1:0]      exe_dst_o,
    output logic                  exe_side_o,
    output logic [DATA_W-1:0]     exe_lhs_o,
    output logic [DATA_W-1:0]     exe_rhs_o,
    output logic [IDX_W-1:0]      exe_src_o,
    output logic                  err_o
);

    op_t              cfg_op  [CELLS];
    cell_idx_t        cfg_dst [CELLS];
    slot_t            lhs_q   [CELLS];
    slot_t            rhs_q   [CELLS];
    logic [CELLS-1:0] pend_vec;
    logic [CELLS-1:0] lfull_vec;
    logic [CELLS-1:0] rfull_vec;
    logic [CELLS-1:0] ready_vec;
    logic [CELLS-1:0] drop_vec;
    logic [CELLS-1:0] ack_clr;
    logic [CELLS-1:0] grant;
    cell_idx_t        grant_idx;
    logic             grant_any;
    slot_t            sel_lhs;
    slot_t            sel_rhs;
    packet_t          fire_pkt;
    packet_t          exe_q;
    logic             exe_v_q;
    logic             err_q;

    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        assign cfg_op[g]  = cfg_op_i[g*OP_W +: OP_W];
        assign cfg_dst[g] = cfg_dst_i[g*IDX_W +: IDX_W];

        dflow_cell u_cell (
            .clk          (clk),
            .rst          (rst),
            .wr_en        (tok_valid_i && (tok_dst_i == cell_idx_t'(g))),
            .wr_side      (side_e'(tok_side_i)),
            .wr_data      (tok_data_i),
            .wr_src       (tok_src_i),
            .wr_from_cell (tok_from_cell_i),
            .fire         (grant[g]),
            .ack_clr      (ack_clr[g]),
            .lhs_q        (lhs_q[g]),
            .rhs_q        (rhs_q[g]),
            .pend_q       (pend_vec[g]),
            .ready        (ready_vec[g]),
            .drop         (drop_vec[g])
        );

        assign lfull_vec[g] = lhs_q[g].full;
        assign rfull_vec[g] = rhs_q[g].full;
    end

    dflow_rr_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (ready_vec),
        .gnt     (grant),
        .gnt_idx (grant_idx),
        .gnt_any (grant_any)
    );

    assign sel_lhs = lhs_q[grant_idx];
    assign sel_rhs = rhs_q[grant_idx];

    always_comb begin
        fire_pkt.op   = cfg_op[grant_idx];
        fire_pkt.dst  = cfg_dst[grant_idx];
        fire_pkt.side = side_e'(cfg_side_i[grant_idx]);
        fire_pkt.lhs  = sel_lhs.data;
        fire_pkt.rhs  = sel_rhs.data;
        fire_pkt.src  = grant_idx;
    end

    // R6/R7: release producer arcs on consumption, or from outside
    always_comb begin
        for (int i = 0; i < CELLS; i++) begin
            ack_clr[i] = ext_ack_i[i]
                | (grant_any && sel_lhs.from_cell && (sel_lhs.src == cell_idx_t'(i)))
                | (grant_any && sel_rhs.from_cell && (sel_rhs.src == cell_idx_t'(i)));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exe_v_q <= 1'b0;
            exe_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            exe_v_q <= grant_any;
            if (grant_any) exe_q <= fire_pkt;
            err_q   <= |drop_vec;
        end
    end

    assign exe_valid_o = exe_v_q;
    assign exe_op_o    = exe_q.op;
    assign exe_dst_o   = exe_q.dst;
    assign exe_side_o  = exe_q.side;
    assign exe_lhs_o   = exe_q.lhs;
    assign exe_rhs_o   = exe_q.rhs;
    assign exe_src_o   = exe_q.src;
    assign err_o       = err_q;

endmodule

// File: rtl/dflow_cell_array_chk.sv
module dflow_cell_array_chk
    import dflow_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tok_valid_i,
    input logic [IDX_W-1:0] tok_dst_i,
    input logic             tok_side_i,
    input logic             exe_valid_o,
    input logic [IDX_W-1:0] exe_src_o,
    input logic             err_o,
    input logic [CELLS-1:0] grant,
    input logic [CELLS-1:0] pend_vec,
    input logic [CELLS-1:0] lfull_vec,
    input logic [CELLS-1:0] rfull_vec
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!exe_valid_o && !err_o));

    a_r2_left_fill: assert property (@(posedge clk) disable iff (rst)
        (tok_valid_i && !tok_side_i && !lfull_vec[tok_dst_i]) |=> lfull_vec[$past(tok_dst_i)]);

    a_r2_right_fill: assert property (@(posedge clk) disable iff (rst)
        (tok_valid_i && tok_side_i && !rfull_vec[tok_dst_i]) |=> rfull_vec[$past(tok_dst_i)]);

    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        exe_valid_o |=> !(exe_valid_o && (exe_src_o == $past(exe_src_o))));

    a_r5_busy_after_issue: assert property (@(posedge clk) disable iff (rst)
        exe_valid_o |-> pend_vec[exe_src_o]);

    a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r9_error_needs_token: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(tok_valid_i));

endmodule

bind dflow_cell_array dflow_cell_array_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tok_valid_i (tok_valid_i),
    .tok_dst_i   (tok_dst_i),
    .tok_side_i  (tok_side_i),
    .exe_valid_o (exe_valid_o),
    .exe_src_o   (exe_src_o),
    .err_o       (err_o),
    .grant       (grant),
    .pend_vec    (pend_vec),
    .lfull_vec   (lfull_vec),
    .rfull_vec   (rfull_vec)
);

// File: tb/test_dflow_cell_array.sv
module test_dflow_cell_array;
    import dflow_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [CELLS*OP_W-1:0]  cfg_op;
    logic [CELLS*IDX_W-1:0] cfg_dst;
    logic [CELLS-1:0]       cfg_side;
    logic                   tok_valid;
    logic [IDX_W-1:0]       tok_dst;
    logic                   tok_side;
    logic [DATA_W-1:0]      tok_data;
    logic [IDX_W-1:0]       tok_src;
    logic                   tok_fc;
    logic [CELLS-1:0]       ext_ack;
    logic                   exe_valid;
    logic [OP_W-1:0]        exe_op;
    logic [IDX_W-1:0]       exe_dst;
    logic                   exe_side;
    logic [DATA_W-1:0]      exe_lhs;
    logic [DATA_W-1:0]      exe_rhs;
    logic [IDX_W-1:0]       exe_src;
    logic                   err;

    dflow_cell_array i_dflow_cell_array (
        .clk(clk), .rst(rst),
        .cfg_op_i(cfg_op), .cfg_dst_i(cfg_dst), .cfg_side_i(cfg_side),
        .tok_valid_i(tok_valid), .tok_dst_i(tok_dst), .tok_side_i(tok_side),
        .tok_data_i(tok_data), .tok_src_i(tok_src), .tok_from_cell_i(tok_fc),
        .ext_ack_i(ext_ack),
        .exe_valid_o(exe_valid), .exe_op_o(exe_op), .exe_dst_o(exe_dst),
        .exe_side_o(exe_side), .exe_lhs_o(exe_lhs), .exe_rhs_o(exe_rhs),
        .exe_src_o(exe_src), .err_o(err)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string phase  = "R1";

    // Behavioural reference state
    bit          m_av   [CELLS];
    bit          m_bv   [CELLS];
    bit          m_pend [CELLS];
    bit          m_afc  [CELLS];
    bit          m_bfc  [CELLS];
    int          m_asrc [CELLS];
    int          m_bsrc [CELLS];
    logic [15:0] m_ad   [CELLS];
    logic [15:0] m_bd   [CELLS];
    int          m_ptr;
    bit          m_exe_v;
    bit          m_err;
    logic [44:0] m_pkt;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < CELLS; i++) begin
            m_av[i] = 0; m_bv[i] = 0; m_pend[i] = 0; m_afc[i] = 0; m_bfc[i] = 0;
            m_asrc[i] = 0; m_bsrc[i] = 0; m_ad[i] = '0; m_bd[i] = '0;
        end
        m_ptr = 0; m_exe_v = 0; m_err = 0; m_pkt = '0;
    endtask

    task automatic model_step();
        int               g;
        bit               wr;
        logic [CELLS-1:0] ackv;
        g = -1; wr = 0; ackv = ext_ack;
        for (int k = 0; k < CELLS; k++) begin
            int idx;
            idx = (m_ptr + k) % CELLS;
            if (g < 0 && m_av[idx] && m_bv[idx] && !m_pend[idx]) g = idx;
        end
        m_err = 0;
        if (tok_valid) begin
            if (tok_side == 1'b0 ? m_av[tok_dst] : m_bv[tok_dst]) m_err = 1;
            else wr = 1;
        end
        m_exe_v = (g >= 0);
        if (g >= 0) begin
            m_pkt = {cfg_op[g*OP_W +: OP_W], cfg_dst[g*IDX_W +: IDX_W], cfg_side[g],
                     m_ad[g], m_bd[g], 3'(g)};
            if (m_afc[g]) ackv[m_asrc[g]] = 1'b1;
            if (m_bfc[g]) ackv[m_bsrc[g]] = 1'b1;
            m_av[g] = 0; m_bv[g] = 0;
            m_ptr = (g + 1) % CELLS;
        end
        for (int i = 0; i < CELLS; i++) begin
            if (i == g) m_pend[i] = 1;
            else if (ackv[i]) m_pend[i] = 0;
        end
        if (wr) begin
            if (tok_side == 1'b0) begin
                m_av[tok_dst] = 1; m_ad[tok_dst] = tok_data;
                m_asrc[tok_dst] = int'(tok_src); m_afc[tok_dst] = tok_fc;
            end else begin
                m_bv[tok_dst] = 1; m_bd[tok_dst] = tok_data;
                m_bsrc[tok_dst] = int'(tok_src); m_bfc[tok_dst] = tok_fc;
            end
        end
    endtask

    task automatic compare();
        logic [63:0] act;
        logic [63:0] exp;
        act = {17'd0, exe_valid, err, (exe_valid ? {exe_op, exe_dst, exe_side, exe_lhs, exe_rhs, exe_src} : 44'd0)};
        exp = {17'd0, m_exe_v,  m_err, (m_exe_v ? m_pkt[43:0] : 44'd0)};
        chk(act == exp, {phase, " per-cycle model"}, act, exp);
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        tok_valid = 0;
        ext_ack   = '0;
    endtask

    task automatic send(input int dst, input int side, input logic [15:0] data,
                        input int src, input bit fc);
        tok_valid = 1;
        tok_dst   = 3'(dst);
        tok_side  = side[0];
        tok_data  = data;
        tok_src   = 3'(src);
        tok_fc    = fc;
        cycle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < CELLS; i++) begin
            cfg_op[i*OP_W +: OP_W]    = 4'(i + 1);
            cfg_dst[i*IDX_W +: IDX_W] = 3'((i + 1) % CELLS);
            cfg_side[i]               = 1'b0;
        end
        tok_valid = 0; tok_dst = '0; tok_side = 0; tok_data = '0;
        tok_src = '0; tok_fc = 0; ext_ack = '0;
        model_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: quiet after reset
        phase = "R1";
        chk(!exe_valid && !err, "R1 reset outputs", {62'd0, exe_valid, err}, 64'd0);
        cycle();
        cycle();

        // R3: single operand never fires
        phase = "R3";
        send(0, 0, 16'h1111, 0, 0);
        cycle();
        chk(!exe_valid, "R3 lone operand does not fire", 64'(exe_valid), 64'd0);

        // R2 / R4: complete the pair, issue one cycle later
        phase = "R4";
        send(0, 1, 16'h2222, 0, 0);
        chk(!exe_valid, "R4 no issue in write cycle", 64'(exe_valid), 64'd0);
        cycle();
        chk(exe_valid && exe_src == 0 && exe_op == 1 && exe_dst == 1 && exe_side == 0,
            "R4 packet header", {48'd0, 4'(exe_valid), exe_op, 4'(exe_dst), 1'b0, exe_src},
            {48'd0, 4'd1, 4'd1, 4'd1, 1'b0, 3'd0});
        chk(exe_lhs == 16'h1111 && exe_rhs == 16'h2222, "R2 operands in their slots",
            {32'd0, exe_lhs, exe_rhs}, {32'd0, 16'h1111, 16'h2222});
        cycle();
        chk(!exe_valid, "R4 valid lasts one cycle", 64'(exe_valid), 64'd0);

        // R5: refill while arc busy, no refire
        phase = "R5";
        send(0, 0, 16'h0101, 0, 0);
        send(0, 1, 16'h0202, 0, 0);
        for (int n = 0; n < 3; n++) begin
            cycle();
            chk(!exe_valid, "R5 busy arc blocks refire", 64'(exe_valid), 64'd0);
        end

        // R7: external release lets it fire
        phase = "R7";
        ext_ack = 8'b0000_0001;
        cycle();
        cycle();
        chk(exe_valid && exe_src == 0 && exe_lhs == 16'h0101, "R7 fires after external release",
            {44'd0, 1'b0, exe_src, exe_lhs}, {44'd0, 1'b0, 3'd0, 16'h0101});

        // R6: consumer firing releases producer
        phase = "R6";
        send(1, 0, 16'h3333, 0, 1);
        send(1, 1, 16'h4444, 0, 0);
        cycle();
        chk(exe_valid && exe_src == 1, "R6 consumer issues", {60'd0, 1'b0, exe_src}, 64'd1);
        send(0, 0, 16'h0005, 0, 0);
        send(0, 1, 16'h0006, 0, 0);
        cycle();
        chk(exe_valid && exe_src == 0 && exe_rhs == 16'h0006, "R6 producer released by consumption",
            {44'd0, 1'b0, exe_src, exe_rhs}, {44'd0, 1'b0, 3'd0, 16'h0006});

        // R9: token into full slot dropped with error
        phase = "R9";
        send(3, 0, 16'hAAAA, 0, 0);
        send(3, 0, 16'hBBBB, 0, 0);
        chk(err, "R9 error on full slot", 64'(err), 64'd1);
        cycle();
        chk(!err, "R9 error is one cycle", 64'(err), 64'd0);
        send(3, 1, 16'h0001, 0, 0);
        cycle();
        chk(exe_valid && exe_src == 3 && exe_lhs == 16'hAAAA, "R9 old value kept",
            {44'd0, 1'b0, exe_src, exe_lhs}, {44'd0, 1'b0, 3'd3, 16'hAAAA});

        // R10: token into the cell firing at the same edge
        phase = "R10";
        send(4, 0, 16'h0005, 0, 0);
        send(4, 1, 16'h0006, 0, 0);
        send(4, 0, 16'h0007, 0, 0);
        chk(exe_valid && exe_src == 4 && exe_lhs == 16'h0005 && err, "R10 issue plus drop",
            {43'd0, err, 1'b0, exe_src, exe_lhs}, {43'd0, 1'b1, 1'b0, 3'd4, 16'h0005});
        ext_ack = 8'b0001_0000;
        cycle();
        send(4, 1, 16'h0008, 0, 0);
        for (int n = 0; n < 3; n++) begin
            cycle();
            chk(!exe_valid, "R10 dropped token not stored", 64'(exe_valid), 64'd0);
        end

        // R8: release three waiting cells at once; search starts at 5
        phase = "R8";
        send(0, 0, 16'h0010, 0, 0);
        send(0, 1, 16'h0011, 0, 0);
        send(1, 0, 16'h0012, 0, 0);
        send(1, 1, 16'h0013, 0, 0);
        send(3, 0, 16'h0014, 0, 0);
        send(3, 1, 16'h0015, 0, 0);
        ext_ack = 8'b0000_1011;
        cycle();
        for (int n = 0; n < 3; n++) begin
            int e;
            e = (n == 2) ? 3 : n;
            cycle();
            chk(exe_valid && int'(exe_src) == e, "R8 round-robin order",
                {60'd0, 1'b0, exe_src}, 64'(e));
        end
        cycle();
        chk(!exe_valid, "R8 nothing left to issue", 64'(exe_valid), 64'd0);

        // R11: fire and external release at the same edge
        phase = "R11";
        send(5, 0, 16'h0001, 0, 0);
        send(5, 1, 16'h0002, 0, 0);
        ext_ack = 8'b0010_0000;
        cycle();
        chk(exe_valid && exe_src == 5, "R11 issue", {60'd0, 1'b0, exe_src}, 64'd5);
        send(5, 0, 16'h0003, 0, 0);
        send(5, 1, 16'h0004, 0, 0);
        for (int n = 0; n < 3; n++) begin
            cycle();
            chk(!exe_valid, "R11 arc stays busy", 64'(exe_valid), 64'd0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule